// File: doc/BRIEF.md
# Isochronous Buffer Streaming Port

This block gives a host processor sequential access to two on-chip packet buffers, one per isochronous transfer list, through a single 16-bit data register. The processor first programs a byte count into a transfer counter register. It then issues a one-byte command that names the buffer and the direction, and moves words one after another. An internal byte pointer starts at address zero for every command and steps by two bytes on each accepted word. There is no way to seek to an arbitrary address through this port.

When a word access brings the pointer to or past the programmed count, the transfer ends. At that point the block sets a sticky end-of-transfer interrupt flag and updates a per-buffer "filled" status bit: a finished write sets the bit and a finished read clears it. Any data access made while no transfer is running is dropped. A separate 16-bit register holds the number of bytes allocated to isochronous buffering. The block only stores that value and presents it.

The control state machine has four states:
- `ST_IDLE`: no command accepted since reset.
- `ST_READ`: streaming words out of the selected buffer.
- `ST_WRITE`: streaming words into the selected buffer.
- `ST_DONE`: count reached; further accesses are dropped.

It has these transitions:
- any state to `ST_READ` or `ST_WRITE`, on a legal command with a nonzero count;
- any state to `ST_DONE`, on a legal command with a zero count;
- `ST_READ` or `ST_WRITE` to `ST_DONE`, on the word that reaches the count.

A legal command always wins over a data access in the same cycle.

Top module: `isoc_stream_port`

## Requirements
- R1: After reset, `eot_irq`, `buf_full`, `busy`, `data_rdata` and `buf_size` are all zero.
- R2: Only the command codes 40h (read buffer 0), 42h (read buffer 1), C0h (write buffer 0) and C2h (write buffer 1) are accepted. Bit 7 selects write (1) or read (0), and bit 1 selects the buffer. Any other code has no effect, including during a running transfer.
- R3: Each accepted command restarts the byte pointer at 0000h, so the first word moved is word 0 of the selected buffer.
- R4: Each accepted word access advances the pointer by 2 bytes. During a read transfer, `data_rdata` shows the word at the current pointer before the `data_rd` strobe. Outside a read transfer it shows 0000h.
- R5: The transfer length is the counter value held when the command is accepted. Loading the counter during a transfer does not change that transfer.
- R6: On the clock edge of the word access that makes pointer+2 reach or exceed the count, `eot_irq` is set and `busy` falls.
- R7: With an odd byte count N, the transfer ends after (N+1)/2 words.
- R8: `eot_irq` stays at 1 until `irq_clear` is pulsed. A completion in the same cycle as a clear leaves it at 1.
- R9: Completing a write to buffer b sets `buf_full[b]`, and completing a read from buffer b clears it. The other buffer's bit is unchanged.
- R10: Data accesses made while no transfer is running change neither the buffer contents nor the pointer.
- R11: A new command during a transfer aborts it without setting `eot_irq` or changing `buf_full`.
- R12: A legal command issued while the count is zero completes at once, on the command's clock edge.
- R13: `buf_size` takes `size_value` on a `size_load` pulse and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| cnt_load | input | 1 | Load strobe for the transfer byte count |
| cnt_value | input | 16 | Transfer byte count |
| size_load | input | 1 | Load strobe for the buffer-size register |
| size_value | input | 16 | Buffer size in bytes |
| data_wr | input | 1 | Write-word strobe on the data register |
| data_wdata | input | 16 | Word written to the data register |
| data_rd | input | 1 | Read-word strobe on the data register |
| data_rdata | output | 16 | Word at the pointer during a read transfer, else 0 |
| irq_clear | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| eot_irq | output | 1 | Sticky end-of-transfer interrupt flag |
| buf_full | output | 2 | Per-buffer filled status bits |
| busy | output | 1 | A read or write transfer is running |
| buf_size | output | 16 | Buffer-size register value |

## Verification
The buffers are filled with distinct word patterns, one per buffer. A long preload followed by a short overwrite shows whether extra strobes after completion leaked into memory, because the stale preload words must still appear where dropped writes would have landed. An odd byte count next to an even one separates ceiling from floor word counting. A mid-transfer abort that is followed by a read from word zero proves that the pointer restarts. An illegal code injected during a read, a count reload during a write, and a zero count each test one path of the command and counter handling.

// File: rtl/isoc_port_pkg.sv
package isoc_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } port_state_t;

    typedef struct packed {
        logic ok;
        logic is_write;
        logic buf_sel;
    } port_cmd_t;

    // Fixed pattern bits of a legal command byte (bits 7 and 1 are free)
    localparam logic [7:0] CMD_FIXED_MASK  = 8'h7D;
    localparam logic [7:0] CMD_FIXED_VALUE = 8'h40;
    localparam int         CMD_DIR_BIT     = 7;
    localparam int         CMD_BUF_BIT     = 1;
    localparam int         BYTES_PER_WORD  = 2;

endpackage

// File: rtl/isoc_cmd_decode.sv
module isoc_cmd_decode
    import isoc_port_pkg::*;
(
    input  logic       valid_in,
    input  logic [7:0] code_in,
    output port_cmd_t  cmd_out
);
    always_comb begin
        cmd_out.ok       = valid_in && ((code_in & CMD_FIXED_MASK) == CMD_FIXED_VALUE);
        cmd_out.is_write = code_in[CMD_DIR_BIT];
        cmd_out.buf_sel  = code_in[CMD_BUF_BIT];
    end
endmodule

// File: rtl/isoc_byte_ptr.sv
module isoc_byte_ptr
    import isoc_port_pkg::*;
#(
    parameter int PTR_W = 16
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PTR_W-1:0] limit_in,
    input  logic             step,
    output logic [PTR_W-1:0] ptr_q,
    output logic             at_last
);
    localparam logic [PTR_W:0] STEP_EXT = (PTR_W+1)'(BYTES_PER_WORD);

    logic [PTR_W-1:0] limit_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            limit_q <= '0;
        end else if (restart) begin
            ptr_q   <= '0;
            limit_q <= limit_in;
        end else if (step) begin
            ptr_q   <= ptr_q + PTR_W'(BYTES_PER_WORD);
        end
    end

    // Widened compare so the pointer's carry is never lost
    assign at_last = ({1'b0, ptr_q} + STEP_EXT) >= {1'b0, limit_q};
endmodule

// File: rtl/isoc_buf_ram.sv
module isoc_buf_ram #(
    parameter int NBUF   = 2,
    parameter int WORDS  = 64,
    parameter int DATA_W = 16,
    localparam int AW    = $clog2(WORDS),
    localparam int SW    = (NBUF > 1) ? $clog2(NBUF) : 1
)(
    input  logic              clk,
    input  logic              we,
    input  logic [SW-1:0]     bank,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] bank_rd [NBUF];

    for (genvar g = 0; g < NBUF; g++) begin : g_bank
        logic [DATA_W-1:0] mem [WORDS];

        always_ff @(posedge clk) begin
            if (we && (bank == SW'(g))) begin
                mem[addr] <= wdata;
            end
        end

        assign bank_rd[g] = mem[addr];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (bank == SW'(i)) rdata = bank_rd[i];
        end
    end
endmodule

// File: rtl/isoc_stream_port.sv
module isoc_stream_port
    import isoc_port_pkg::*;
#(
    parameter int BUF_WORDS = 64,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 16
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic              cnt_load,
    input  logic [CNT_W-1:0]  cnt_value,
    input  logic              size_load,
    input  logic [15:0]       size_value,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              data_rd,
    output logic [DATA_W-1:0] data_rdata,
    input  logic              irq_clear,
    output logic              eot_irq,
    output logic [1:0]        buf_full,
    output logic              busy,
    output logic [15:0]       buf_size
);
    localparam int AW   = $clog2(BUF_WORDS);
    localparam int NBUF = 2;

    port_state_t      state_q, state_nx;
    port_cmd_t        cmd;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] byte_ptr;
    logic             at_last;
    logic             act_buf_q;
    logic             cnt_zero;
    logic             xfer_step;
    logic             finish;
    logic             fin_write;
    logic             fin_buf;
    logic [DATA_W-1:0] ram_rdata;

    isoc_cmd_decode u_dec (
        .valid_in (cmd_valid),
        .code_in  (cmd_code),
        .cmd_out  (cmd)
    );

    isoc_byte_ptr #(.PTR_W(CNT_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (cmd.ok),
        .limit_in (cnt_q),
        .step     (xfer_step),
        .ptr_q    (byte_ptr),
        .at_last  (at_last)
    );

    isoc_buf_ram #(.NBUF(NBUF), .WORDS(BUF_WORDS), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (xfer_step && (state_q == ST_WRITE)),
        .bank  (act_buf_q),
        .addr  (byte_ptr[AW:1]),
        .wdata (data_wdata),
        .rdata (ram_rdata)
    );

    // Programmable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            buf_size <= '0;
        end else begin
            if (cnt_load)  cnt_q    <= cnt_value;
            if (size_load) buf_size <= size_value;
        end
    end

    assign cnt_zero = (cnt_q == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        if (cmd.ok) begin
            if (cnt_zero)          state_nx = ST_DONE;
            else if (cmd.is_write) state_nx = ST_WRITE;
            else                   state_nx = ST_READ;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_READ:  if (data_rd && at_last) state_nx = ST_DONE;
                ST_WRITE: if (data_wr && at_last) state_nx = ST_DONE;
                ST_DONE:  state_nx = ST_DONE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // Transfer events
    always_comb begin
        xfer_step = 1'b0;
        if (!cmd.ok) begin
            unique case (state_q)
                ST_READ:  xfer_step = data_rd;
                ST_WRITE: xfer_step = data_wr;
                default:  xfer_step = 1'b0;
            endcase
        end
        finish    = (xfer_step && at_last) || (cmd.ok && cnt_zero);
        fin_write = cmd.ok ? cmd.is_write : (state_q == ST_WRITE);
        fin_buf   = cmd.ok ? cmd.buf_sel  : act_buf_q;
    end

    // Output process: flag, status, active buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eot_irq   <= 1'b0;
            buf_full  <= '0;
            act_buf_q <= 1'b0;
        end else begin
            if (cmd.ok) act_buf_q <= cmd.buf_sel;
            if (finish) begin
                eot_irq           <= 1'b1;
                buf_full[fin_buf] <= fin_write;
            end else if (irq_clear) begin
                eot_irq <= 1'b0;
            end
        end
    end

    assign busy       = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign data_rdata = (state_q == ST_READ) ? ram_rdata : '0;
endmodule

// File: rtl/isoc_stream_port_chk.sv
module isoc_stream_port_chk #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
)(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [7:0]        cmd_code,
    input logic              irq_clear,
    input logic              eot_irq,
    input logic [1:0]        buf_full,
    input logic              busy,
    input logic [DATA_W-1:0] data_rdata,
    input logic [CNT_W-1:0]  cur_ptr
);
    logic legal_cmd;
    assign legal_cmd = cmd_valid &&
        ((cmd_code == 8'h40) || (cmd_code == 8'h42) ||
         (cmd_code == 8'hC0) || (cmd_code == 8'hC2));

    assert_cmd_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        legal_cmd |=> (cur_ptr == '0) && (busy || eot_irq));

    assert_ptr_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cur_ptr[0] == 1'b0);

    assert_rdata_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (data_rdata == '0));

    assert_busy_fall_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> eot_irq);

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_irq && !irq_clear) |=> eot_irq);

    assert_status_with_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(buf_full) |-> eot_irq);
endmodule

bind isoc_stream_port isoc_stream_port_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .irq_clear  (irq_clear),
    .eot_irq    (eot_irq),
    .buf_full   (buf_full),
    .busy       (busy),
    .data_rdata (data_rdata),
    .cur_ptr    (byte_ptr)
);

// File: tb/sim_isoc_stream_port.sv
`timescale 1ns/1ps
module sim_isoc_stream_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic        cnt_load = 1'b0;
    logic [15:0] cnt_value = '0;
    logic        size_load = 1'b0;
    logic [15:0] size_value = '0;
    logic        data_wr = 1'b0;
    logic [15:0] data_wdata = '0;
    logic        data_rd = 1'b0;
    logic [15:0] data_rdata;
    logic        irq_clear = 1'b0;
    logic        eot_irq;
    logic [1:0]  buf_full;
    logic        busy;
    logic [15:0] buf_size;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    isoc_stream_port u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cnt_load(cnt_load), .cnt_value(cnt_value),
        .size_load(size_load), .size_value(size_value),
        .data_wr(data_wr), .data_wdata(data_wdata),
        .data_rd(data_rd), .data_rdata(data_rdata),
        .irq_clear(irq_clear), .eot_irq(eot_irq),
        .buf_full(buf_full), .busy(busy), .buf_size(buf_size)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic load_cnt(input logic [15:0] v);
        cnt_load = 1'b1; cnt_value = v;
        @(negedge clk);
        cnt_load = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic push(input logic [15:0] w);
        data_wr = 1'b1; data_wdata = w;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic pop_chk(input string req, input logic [15:0] exp);
        chk_eq(req, data_rdata, exp);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic clr_irq();
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
    endtask

    task automatic t_reset();
        chk_eq("R1 irq", eot_irq, 0);
        chk_eq("R1 full", buf_full, 0);
        chk_eq("R1 busy", busy, 0);
        chk_eq("R1 rdata", data_rdata, 0);
        chk_eq("R1 size", buf_size, 0);
    endtask

    task automatic t_size();
        size_load = 1'b1; size_value = 16'h0300;
        @(negedge clk);
        size_load = 1'b0; size_value = 16'h1111;
        @(negedge clk);
        chk_eq("R13 size held", buf_size, 16'h0300);
    endtask

    task automatic t_idle_ignored();
        // R10: before any command, strobes do nothing
        push(16'hDEAD);
        data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
        chk_eq("R10 idle busy", busy, 0);
        chk_eq("R10 idle irq", eot_irq, 0);
        // R2: illegal command while idle
        send_cmd(8'h80);
        chk_eq("R2 illegal idle busy", busy, 0);
    endtask

    task automatic t_preload_and_overwrite();
        load_cnt(16'd20);
        send_cmd(8'hC0);
        chk_eq("R3 write started", busy, 1);
        for (int i = 0; i < 10; i++) push(16'hC000 + 16'(i));
        chk_eq("R6 preload done irq", eot_irq, 1);
        chk_eq("R9 full0 set", buf_full, 2'b01);
        clr_irq();
        chk_eq("R8 cleared", eot_irq, 0);
        load_cnt(16'd4);
        send_cmd(8'hC0);
        push(16'hA000);
        chk_eq("R6 not yet", eot_irq, 0);
        // completion coinciding with a clear: set wins
        irq_clear = 1'b1;
        push(16'hA001);
        irq_clear = 1'b0;
        chk_eq("R8 set wins", eot_irq, 1);
        chk_eq("R6 busy low", busy, 0);
        // R10: extra writes after completion are dropped
        push(16'hDEAD);
        push(16'hBEEF);
        repeat (3) @(negedge clk);
        chk_eq("R8 sticky", eot_irq, 1);
        clr_irq();
        load_cnt(16'd8);
        send_cmd(8'h40);
        pop_chk("R3 word0", 16'hA000);
        pop_chk("R4 word1", 16'hA001);
        pop_chk("R10 word2 kept", 16'hC002);
        pop_chk("R10 word3 kept", 16'hC003);
        chk_eq("R6 read done", eot_irq, 1);
        chk_eq("R9 full0 cleared", buf_full, 2'b00);
        chk_eq("R4 rdata quiet", data_rdata, 0);
        clr_irq();
    endtask

    task automatic t_odd_buf1();
        load_cnt(16'd5);
        send_cmd(8'hC2);
        push(16'h1111);
        push(16'h2222);
        chk_eq("R7 still busy", busy, 1);
        push(16'h3333);
        chk_eq("R7 odd done", eot_irq, 1);
        chk_eq("R9 full1 only", buf_full, 2'b10);
        clr_irq();
        load_cnt(16'd6);
        send_cmd(8'h42);
        pop_chk("R2 buf1 w0", 16'h1111);
        // R2: illegal code mid-read is ignored
        send_cmd(8'h41);
        chk_eq("R2 illegal mid busy", busy, 1);
        pop_chk("R2 buf1 w1", 16'h2222);
        pop_chk("R2 buf1 w2", 16'h3333);
        chk_eq("R9 full1 cleared", buf_full, 2'b00);
        clr_irq();
        load_cnt(16'd2);
        send_cmd(8'h40);
        pop_chk("R2 buf0 separate", 16'hA000);
        clr_irq();
    endtask

    task automatic t_abort();
        load_cnt(16'd8);
        send_cmd(8'hC0);
        push(16'hE000);
        push(16'hE001);
        send_cmd(8'h40);
        chk_eq("R11 no irq", eot_irq, 0);
        chk_eq("R11 full kept", buf_full, 2'b00);
        pop_chk("R3 restart w0", 16'hE000);
        pop_chk("R3 restart w1", 16'hE001);
        pop_chk("R11 w2", 16'hC002);
        pop_chk("R11 w3", 16'hC003);
        chk_eq("R6 after abort", eot_irq, 1);
        clr_irq();
    endtask

    task automatic t_latch();
        load_cnt(16'd4);
        send_cmd(8'hC2);
        push(16'h5555);
        load_cnt(16'd100);
        push(16'h6666);
        chk_eq("R5 latched len irq", eot_irq, 1);
        chk_eq("R5 latched len busy", busy, 0);
        clr_irq();
    endtask

    task automatic t_zero();
        load_cnt(16'd0);
        send_cmd(8'h40);
        chk_eq("R12 zero irq", eot_irq, 1);
        chk_eq("R12 zero busy", busy, 0);
        chk_eq("R12 read clears", buf_full, 2'b10 & buf_full);
        clr_irq();
        send_cmd(8'hC0);
        chk_eq("R12 zero write full", buf_full[0], 1);
        clr_irq();
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_size();
        t_idle_ignored();
        t_preload_and_overwrite();
        t_odd_buf1();
        t_abort();
        t_latch();
        t_zero();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule